// File: doc/BRIEF.md
# Configuration TLV Stream Decoder

This block sits between a word-wide configuration channel and a logic-analyzer capture engine. It accepts 16-bit words over a valid/ready interface and looks for a two-word opening sync. It then reads a run of type/length records until a two-word closing sync arrives. Each record is checked against a fixed table of field types and lengths. Its payload lands in a shadow copy of the capture settings: mode word, sample-clock divider, sample count, trigger position, global trigger word, two auxiliary trigger words, and ten per-stage trigger arrays.

The settings seen by the capture engine change only when a whole frame has been accepted. When that happens the shadow copy is moved to the live outputs and a one-cycle done pulse is raised. A malformed frame raises an error flag and sends the decoder back to sync hunting. The live settings are not touched. At the start of every frame the shadow copy is reloaded from the live one, so a frame only needs to carry the fields it changes.

Top module: `cfg_frame_decoder`

## Requirements
- R1: Words are ignored until 0xF5A5 is accepted twice in a row. Headers, payload and closing sync seen before that produce neither a done pulse nor an error, and leave every output unchanged.
- R2: A header word holds the field type in bits 15:8 and the payload length, in words, in bits 7:0. Any number of 0xFFFF words may stand where a header is expected and are skipped. 32-bit values and sync patterns arrive upper half first.
- R3: Scalar fields are routed as follows:
  - type 0 sets the mode word (length 1);
  - type 7 sets the global trigger word (length 1);
  - types 1, 3, 5, 10 and 12 (length 2 each) set the divider, sample count, trigger position, auxiliary word A and auxiliary word B.
- R4: Array fields carry one word per stage, with length equal to NUM_STAGES, and payload word k goes to stage k. Types 16 and 17 set mask A and mask B, types 20 and 21 value A and B, types 24 and 25 edge A and B, types 28 and 29 count A and B, and types 32 and 33 logic A and B.
- R5: The mode word is decoded as follows:
  - bit 0 drives `trig_enable`;
  - bit 1 drives `clk_external`;
  - bit 2 drives `clk_falling`;
  - bit 3 drives `rle_enable`.
- R6: After the header position, 0xFA5A followed by 0xFA5A ends the frame. `cfg_done` is high for exactly one cycle, the cycle after the last sync word is accepted. `in_ready` is low in that cycle only.
- R7: Live outputs change only in the cycle in which `cfg_done` is high. An aborted frame leaves them as they were.
- R8: An unknown type, a length that does not match the type, or a second closing word other than 0xFA5A sets `cfg_err` in the next cycle and returns the decoder to sync hunting. The flag stays set until a new opening sync completes and clears in the cycle after its second word. `cfg_done` is never high while `cfg_err` is set.
- R9: A field absent from an accepted frame keeps the value of the last accepted frame, even if an aborted frame in between wrote it.
- R10: After reset every live output is zero, `cfg_err` and `cfg_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Input configuration word |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| cfg_done | output | 1 | One-cycle pulse when a frame is committed |
| cfg_err | output | 1 | Frame error flag |
| mode_word | output | 16 | Live mode word |
| trig_enable | output | 1 | Mode bit 0 |
| clk_external | output | 1 | Mode bit 1 |
| clk_falling | output | 1 | Mode bit 2 |
| rle_enable | output | 1 | Mode bit 3 |
| clk_divider | output | 32 | Sample-clock divider |
| sample_count | output | 32 | Samples to capture |
| trig_position | output | 32 | Trigger position |
| trig_global | output | 16 | Global trigger word |
| trig_aux_a | output | 32 | Auxiliary trigger word A |
| trig_aux_b | output | 32 | Auxiliary trigger word B |
| stage_mask_a | output | NUM_STAGES x 16 | Per-stage mask A |
| stage_mask_b | output | NUM_STAGES x 16 | Per-stage mask B |
| stage_value_a | output | NUM_STAGES x 16 | Per-stage value A |
| stage_value_b | output | NUM_STAGES x 16 | Per-stage value B |
| stage_edge_a | output | NUM_STAGES x 16 | Per-stage edge A |
| stage_edge_b | output | NUM_STAGES x 16 | Per-stage edge B |
| stage_count_a | output | NUM_STAGES x 16 | Per-stage count A |
| stage_count_b | output | NUM_STAGES x 16 | Per-stage count B |
| stage_logic_a | output | NUM_STAGES x 16 | Per-stage logic A |
| stage_logic_b | output | NUM_STAGES x 16 | Per-stage logic B |

## Verification
Each result is due exactly one cycle after the word that causes it is accepted:
- the error flag rises one cycle after the offending word;
- it clears one cycle after the second opening sync word;
- the done pulse, the new live values and the low `in_ready` all appear together one cycle after the second closing word.

Words are driven on the falling edge and held across one rising edge, and the driver returns on the next falling edge. Checks made by the driver at that point therefore see the registered result of the word just sent. The monitor samples `cfg_done` on every falling edge and compares the live outputs against the snapshot queued for that frame, so an early, late or extra pulse is caught.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;
    localparam int          WORD_W     = 16;
    localparam logic [15:0] SYNC_OPEN  = 16'hF5A5;
    localparam logic [15:0] SYNC_CLOSE = 16'hFA5A;
    localparam logic [15:0] PAD_WORD   = 16'hFFFF;
    localparam int          NUM_SCAL   = 7;
    localparam int          NUM_ARR    = 10;
    localparam int          SCAL_IDX_W = $clog2(NUM_SCAL);
    localparam int          ARR_IDX_W  = $clog2(NUM_ARR);

    typedef enum logic [SCAL_IDX_W-1:0] {
        SC_MODE  = 3'd0,
        SC_DIV   = 3'd1,
        SC_COUNT = 3'd2,
        SC_TPOS  = 3'd3,
        SC_GLB   = 3'd4,
        SC_AUXA  = 3'd5,
        SC_AUXB  = 3'd6
    } scal_id_e;

    typedef enum logic [2:0] {
        ST_HUNT_HI,
        ST_HUNT_LO,
        ST_HDR,
        ST_PAY,
        ST_END_LO,
        ST_DONE
    } parse_state_e;
endpackage

// File: rtl/cfg_field_lookup.sv
module cfg_field_lookup
    import cfg_dec_pkg::*;
#(
    parameter int NUM_STAGES = 16
) (
    input  logic [7:0]           ftype,
    output logic                 known,
    output logic [7:0]           exp_len,
    output logic                 is_arr,
    output scal_id_e             scal_id,
    output logic [ARR_IDX_W-1:0] arr_id
);
    localparam logic [7:0] ARR_BASE  = 8'd16;
    localparam logic [7:0] ARR_LAST  = 8'd33;
    localparam logic [7:0] STAGE_LEN = 8'(NUM_STAGES);

    logic [7:0] rel;
    assign rel = ftype - ARR_BASE;

    always_comb begin
        known   = 1'b0;
        exp_len = 8'd0;
        is_arr  = 1'b0;
        scal_id = SC_MODE;
        arr_id  = '0;
        case (ftype)
            8'd0:  begin known = 1'b1; exp_len = 8'd1; scal_id = SC_MODE;  end
            8'd1:  begin known = 1'b1; exp_len = 8'd2; scal_id = SC_DIV;   end
            8'd3:  begin known = 1'b1; exp_len = 8'd2; scal_id = SC_COUNT; end
            8'd5:  begin known = 1'b1; exp_len = 8'd2; scal_id = SC_TPOS;  end
            8'd7:  begin known = 1'b1; exp_len = 8'd1; scal_id = SC_GLB;   end
            8'd10: begin known = 1'b1; exp_len = 8'd2; scal_id = SC_AUXA;  end
            8'd12: begin known = 1'b1; exp_len = 8'd2; scal_id = SC_AUXB;  end
            default: begin
                // array types come in pairs every four codes: 16/17, 20/21, ...
                if (ftype >= ARR_BASE && ftype <= ARR_LAST && !ftype[1]) begin
                    known   = 1'b1;
                    exp_len = STAGE_LEN;
                    is_arr  = 1'b1;
                    arr_id  = ARR_IDX_W'({rel[7:2], rel[0]});
                end
            end
        endcase
    end
endmodule

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser
    import cfg_dec_pkg::*;
#(
    parameter int NUM_STAGES = 16,
    localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 in_ready,
    output logic                 frame_open,
    output logic                 frame_commit,
    output logic                 wr_en,
    output logic                 wr_is_arr,
    output scal_id_e             wr_scal,
    output logic [ARR_IDX_W-1:0] wr_arr,
    output logic [STG_W-1:0]     wr_pos,
    output logic                 wr_wide,
    output logic [WORD_W-1:0]    wr_data,
    output logic                 done,
    output logic                 err
);
    typedef struct packed {
        parse_state_e         st;
        logic                 err;
        logic                 is_arr;
        scal_id_e             scal;
        logic [ARR_IDX_W-1:0] arr;
        logic [7:0]           len;
        logic [7:0]           pos;
    } parse_reg_t;

    parse_reg_t q, d;

    logic                 lk_known;
    logic [7:0]           lk_len;
    logic                 lk_is_arr;
    scal_id_e             lk_scal;
    logic [ARR_IDX_W-1:0] lk_arr;
    logic                 accept;

    cfg_field_lookup #(.NUM_STAGES(NUM_STAGES)) u_lookup (
        .ftype   (in_data[15:8]),
        .known   (lk_known),
        .exp_len (lk_len),
        .is_arr  (lk_is_arr),
        .scal_id (lk_scal),
        .arr_id  (lk_arr)
    );

    assign in_ready  = (q.st != ST_DONE);
    assign accept    = in_valid && in_ready;
    assign done      = (q.st == ST_DONE);
    assign err       = q.err;
    assign wr_is_arr = q.is_arr;
    assign wr_scal   = q.scal;
    assign wr_arr    = q.arr;
    assign wr_pos    = STG_W'(q.pos);
    assign wr_wide   = (q.len == 8'd2);
    assign wr_data   = in_data;

    always_comb begin
        d            = q;
        frame_open   = 1'b0;
        frame_commit = 1'b0;
        wr_en        = 1'b0;
        case (q.st)
            ST_HUNT_HI: begin
                if (accept && in_data == SYNC_OPEN) d.st = ST_HUNT_LO;
            end
            ST_HUNT_LO: begin
                if (accept) begin
                    if (in_data == SYNC_OPEN) begin
                        d.st       = ST_HDR;
                        d.err      = 1'b0;
                        frame_open = 1'b1;
                    end else begin
                        d.st = ST_HUNT_HI;
                    end
                end
            end
            ST_HDR: begin
                if (accept) begin
                    if (in_data == PAD_WORD) begin
                        d.st = ST_HDR;
                    end else if (in_data == SYNC_CLOSE) begin
                        d.st = ST_END_LO;
                    end else if (lk_known && in_data[7:0] == lk_len) begin
                        d.st     = ST_PAY;
                        d.is_arr = lk_is_arr;
                        d.scal   = lk_scal;
                        d.arr    = lk_arr;
                        d.len    = lk_len;
                        d.pos    = 8'd0;
                    end else begin
                        d.st  = ST_HUNT_HI;
                        d.err = 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (accept) begin
                    wr_en = 1'b1;
                    if (q.pos == 8'(q.len - 8'd1)) d.st = ST_HDR;
                    else                           d.pos = 8'(q.pos + 8'd1);
                end
            end
            ST_END_LO: begin
                if (accept) begin
                    if (in_data == SYNC_CLOSE) begin
                        d.st         = ST_DONE;
                        frame_commit = 1'b1;
                    end else begin
                        d.st  = ST_HUNT_HI;
                        d.err = 1'b1;
                    end
                end
            end
            ST_DONE: d.st = ST_HUNT_HI;
            default: d.st = ST_HUNT_HI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_HUNT_HI, err: 1'b0, is_arr: 1'b0, scal: SC_MODE,
                   arr: '0, len: 8'd0, pos: 8'd0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_dec_pkg::*;
#(
    parameter int NUM_STAGES = 16,
    localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      frame_open,
    input  logic                                      frame_commit,
    input  logic                                      wr_en,
    input  logic                                      wr_is_arr,
    input  scal_id_e                                  wr_scal,
    input  logic [ARR_IDX_W-1:0]                      wr_arr,
    input  logic [STG_W-1:0]                          wr_pos,
    input  logic                                      wr_wide,
    input  logic [WORD_W-1:0]                         wr_data,
    output logic [NUM_SCAL-1:0][31:0]                 live_scal,
    output logic [NUM_ARR-1:0][NUM_STAGES-1:0][15:0]  live_arr
);
    typedef logic [NUM_SCAL-1:0][31:0]                scal_t;
    typedef logic [NUM_ARR-1:0][NUM_STAGES-1:0][15:0] arr_t;

    typedef struct packed {
        scal_t sh_s;
        arr_t  sh_a;
        scal_t lv_s;
        arr_t  lv_a;
    } bank_t;

    bank_t q, d;

    assign live_scal = q.lv_s;
    assign live_arr  = q.lv_a;

    always_comb begin
        d = q;
        if (frame_open) begin
            d.sh_s = q.lv_s;
            d.sh_a = q.lv_a;
        end
        if (wr_en) begin
            if (wr_is_arr) begin
                d.sh_a[wr_arr][wr_pos] = wr_data;
            end else if (wr_wide) begin
                if (!wr_pos[0]) d.sh_s[wr_scal][31:16] = wr_data;
                else            d.sh_s[wr_scal][15:0]  = wr_data;
            end else begin
                d.sh_s[wr_scal] = {16'h0000, wr_data};
            end
        end
        if (frame_commit) begin
            d.lv_s = q.sh_s;
            d.lv_a = q.sh_a;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cfg_frame_decoder.sv
module cfg_frame_decoder
    import cfg_dec_pkg::*;
#(
    parameter int NUM_STAGES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [15:0]                  in_data,
    output logic                         in_ready,
    output logic                         cfg_done,
    output logic                         cfg_err,
    output logic [15:0]                  mode_word,
    output logic                         trig_enable,
    output logic                         clk_external,
    output logic                         clk_falling,
    output logic                         rle_enable,
    output logic [31:0]                  clk_divider,
    output logic [31:0]                  sample_count,
    output logic [31:0]                  trig_position,
    output logic [15:0]                  trig_global,
    output logic [31:0]                  trig_aux_a,
    output logic [31:0]                  trig_aux_b,
    output logic [NUM_STAGES-1:0][15:0]  stage_mask_a,
    output logic [NUM_STAGES-1:0][15:0]  stage_mask_b,
    output logic [NUM_STAGES-1:0][15:0]  stage_value_a,
    output logic [NUM_STAGES-1:0][15:0]  stage_value_b,
    output logic [NUM_STAGES-1:0][15:0]  stage_edge_a,
    output logic [NUM_STAGES-1:0][15:0]  stage_edge_b,
    output logic [NUM_STAGES-1:0][15:0]  stage_count_a,
    output logic [NUM_STAGES-1:0][15:0]  stage_count_b,
    output logic [NUM_STAGES-1:0][15:0]  stage_logic_a,
    output logic [NUM_STAGES-1:0][15:0]  stage_logic_b
);
    localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

    logic                                     frame_open, frame_commit;
    logic                                     wr_en, wr_is_arr, wr_wide;
    scal_id_e                                 wr_scal;
    logic [ARR_IDX_W-1:0]                     wr_arr;
    logic [STG_W-1:0]                         wr_pos;
    logic [WORD_W-1:0]                        wr_data;
    logic [NUM_SCAL-1:0][31:0]                live_scal;
    logic [NUM_ARR-1:0][NUM_STAGES-1:0][15:0] live_arr;
    logic                                     unused_hi;

    cfg_frame_parser #(.NUM_STAGES(NUM_STAGES)) u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .frame_open   (frame_open),
        .frame_commit (frame_commit),
        .wr_en        (wr_en),
        .wr_is_arr    (wr_is_arr),
        .wr_scal      (wr_scal),
        .wr_arr       (wr_arr),
        .wr_pos       (wr_pos),
        .wr_wide      (wr_wide),
        .wr_data      (wr_data),
        .done         (cfg_done),
        .err          (cfg_err)
    );

    cfg_reg_bank #(.NUM_STAGES(NUM_STAGES)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_open   (frame_open),
        .frame_commit (frame_commit),
        .wr_en        (wr_en),
        .wr_is_arr    (wr_is_arr),
        .wr_scal      (wr_scal),
        .wr_arr       (wr_arr),
        .wr_pos       (wr_pos),
        .wr_wide      (wr_wide),
        .wr_data      (wr_data),
        .live_scal    (live_scal),
        .live_arr     (live_arr)
    );

    assign mode_word     = live_scal[SC_MODE][15:0];
    assign trig_global   = live_scal[SC_GLB][15:0];
    assign unused_hi     = ^{live_scal[SC_MODE][31:16], live_scal[SC_GLB][31:16]};
    assign trig_enable   = mode_word[0];
    assign clk_external  = mode_word[1];
    assign clk_falling   = mode_word[2];
    assign rle_enable    = mode_word[3];
    assign clk_divider   = live_scal[SC_DIV];
    assign sample_count  = live_scal[SC_COUNT];
    assign trig_position = live_scal[SC_TPOS];
    assign trig_aux_a    = live_scal[SC_AUXA];
    assign trig_aux_b    = live_scal[SC_AUXB];
    assign stage_mask_a  = live_arr[0];
    assign stage_mask_b  = live_arr[1];
    assign stage_value_a = live_arr[2];
    assign stage_value_b = live_arr[3];
    assign stage_edge_a  = live_arr[4];
    assign stage_edge_b  = live_arr[5];
    assign stage_count_a = live_arr[6];
    assign stage_count_b = live_arr[7];
    assign stage_logic_a = live_arr[8];
    assign stage_logic_b = live_arr[9];
endmodule

// File: rtl/cfg_frame_decoder_chk.sv
module cfg_frame_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        cfg_done,
    input logic        cfg_err,
    input logic [15:0] mode_word,
    input logic [31:0] clk_divider,
    input logic [31:0] sample_count,
    input logic [31:0] trig_position
);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_done);

    assert_stall_only_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> cfg_done);

    assert_done_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !in_ready);

    assert_hold_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> ($stable(clk_divider) && $stable(sample_count)
                       && $stable(trig_position) && $stable(mode_word)));

    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !cfg_err);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(in_valid && in_ready));
endmodule

bind cfg_frame_decoder cfg_frame_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .cfg_done      (cfg_done),
    .cfg_err       (cfg_err),
    .mode_word     (mode_word),
    .clk_divider   (clk_divider),
    .sample_count  (sample_count),
    .trig_position (trig_position)
);

// File: tb/cfg_frame_decoder_bench.sv
module cfg_frame_decoder_bench;
    localparam int NS = 16;

    typedef struct packed {
        logic [15:0]                mode;
        logic [15:0]                glb;
        logic [31:0]                div;
        logic [31:0]                cnt;
        logic [31:0]                pos;
        logic [31:0]                auxa;
        logic [31:0]                auxb;
        logic [9:0][NS-1:0][15:0]   arr;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] in_data = 16'h0000;
    logic in_ready, cfg_done, cfg_err;
    logic [15:0] mode_word, trig_global;
    logic trig_enable, clk_external, clk_falling, rle_enable;
    logic [31:0] clk_divider, sample_count, trig_position, trig_aux_a, trig_aux_b;
    logic [NS-1:0][15:0] mask_a, mask_b, value_a, value_b, edge_a, edge_b;
    logic [NS-1:0][15:0] count_a, count_b, logic_a, logic_b;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    snap_t m = '0;
    snap_t p = '0;
    snap_t exp_q[$];
    logic [15:0] fw[$];

    always #4 clk = ~clk;

    cfg_frame_decoder #(.NUM_STAGES(NS)) u_cfg_frame_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_done(cfg_done), .cfg_err(cfg_err),
        .mode_word(mode_word), .trig_enable(trig_enable), .clk_external(clk_external),
        .clk_falling(clk_falling), .rle_enable(rle_enable),
        .clk_divider(clk_divider), .sample_count(sample_count),
        .trig_position(trig_position), .trig_global(trig_global),
        .trig_aux_a(trig_aux_a), .trig_aux_b(trig_aux_b),
        .stage_mask_a(mask_a), .stage_mask_b(mask_b),
        .stage_value_a(value_a), .stage_value_b(value_b),
        .stage_edge_a(edge_a), .stage_edge_b(edge_b),
        .stage_count_a(count_a), .stage_count_b(count_b),
        .stage_logic_a(logic_a), .stage_logic_b(logic_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int arr_of(input logic [7:0] t);
        case (t)
            8'd16: return 0;  8'd17: return 1;
            8'd20: return 2;  8'd21: return 3;
            8'd24: return 4;  8'd25: return 5;
            8'd28: return 6;  8'd29: return 7;
            8'd32: return 8;  8'd33: return 9;
            default: return 0;
        endcase
    endfunction

    // every call starts and ends on a falling edge
    task automatic send_word(input logic [15:0] w);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_all();
        foreach (fw[i]) send_word(fw[i]);
        fw.delete();
    endtask

    task automatic fr_open();
        p = m;
        fw.push_back(16'hF5A5);
        fw.push_back(16'hF5A5);
    endtask

    task automatic fr_close();
        fw.push_back(16'hFA5A);
        fw.push_back(16'hFA5A);
    endtask

    task automatic fr_s32(input logic [7:0] t, input logic [31:0] v, input int pads);
        for (int i = 0; i < pads; i++) fw.push_back(16'hFFFF);
        fw.push_back({t, 8'd2});
        fw.push_back(v[31:16]);
        fw.push_back(v[15:0]);
        case (t)
            8'd1:  p.div  = v;
            8'd3:  p.cnt  = v;
            8'd5:  p.pos  = v;
            8'd10: p.auxa = v;
            8'd12: p.auxb = v;
            default: ;
        endcase
    endtask

    task automatic fr_s16(input logic [7:0] t, input logic [15:0] v);
        fw.push_back({t, 8'd1});
        fw.push_back(v);
        if (t == 8'd0) p.mode = v;
        else           p.glb  = v;
    endtask

    task automatic fr_arr(input logic [7:0] t, input logic [15:0] seed);
        fw.push_back(16'hFFFF);
        fw.push_back({t, 8'(NS)});
        for (int k = 0; k < NS; k++) begin
            logic [15:0] w;
            w = 16'(seed + 16'(k) * 16'h0111);
            fw.push_back(w);
            p.arr[arr_of(t)][k] = w;
        end
    endtask

    // good frame: the expected snapshot is queued before sending
    task automatic send_good(input string req);
        m = p;
        exp_q.push_back(p);
        send_all();
        chk(req, "done one cycle after closing sync", {254'd0, cfg_done, in_ready}, 256'd2);
        @(negedge clk);
        chk(req, "done pulse ends", {255'd0, cfg_done}, 256'd0);
    endtask

    task automatic check_hold(input string req);
        chk(req, "divider held",  clk_divider,   m.div);
        chk(req, "count held",    sample_count,  m.cnt);
        chk(req, "position held", trig_position, m.pos);
        chk(req, "mode held",     mode_word,     m.mode);
        chk(req, "mask_a held",   mask_a,        m.arr[0]);
        chk(req, "logic_b held",  logic_b,       m.arr[9]);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cfg_done) begin
            snap_t s;
            done_cnt++;
            if (exp_q.size() == 0) begin
                chk("R6", "unexpected done", 256'd1, 256'd0);
            end else begin
                s = exp_q.pop_front();
                chk("R3", "mode",     mode_word,     s.mode);
                chk("R3", "global",   trig_global,   s.glb);
                chk("R3", "divider",  clk_divider,   s.div);
                chk("R3", "count",    sample_count,  s.cnt);
                chk("R3", "position", trig_position, s.pos);
                chk("R3", "aux_a",    trig_aux_a,    s.auxa);
                chk("R3", "aux_b",    trig_aux_b,    s.auxb);
                chk("R5", "mode flags",
                    {rle_enable, clk_falling, clk_external, trig_enable}, s.mode[3:0]);
                chk("R4", "mask_a",  mask_a,  s.arr[0]);
                chk("R4", "mask_b",  mask_b,  s.arr[1]);
                chk("R4", "value_a", value_a, s.arr[2]);
                chk("R4", "value_b", value_b, s.arr[3]);
                chk("R4", "edge_a",  edge_a,  s.arr[4]);
                chk("R4", "edge_b",  edge_b,  s.arr[5]);
                chk("R4", "count_a", count_a, s.arr[6]);
                chk("R4", "count_b", count_b, s.arr[7]);
                chk("R4", "logic_a", logic_a, s.arr[8]);
                chk("R4", "logic_b", logic_b, s.arr[9]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk("R6", "watchdog expired", 256'd1, 256'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int dc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "ready/done/err", {253'd0, in_ready, cfg_done, cfg_err}, 256'd4);
        check_hold("R10");
        chk("R10", "aux_b zero", trig_aux_b, 256'd0);

        // R1 words before an opening sync are ignored
        fw.push_back(16'h1234); fw.push_back(16'hF5A5); fw.push_back(16'h0001);
        fw.push_back(16'h0001); fw.push_back(16'h0009);
        fw.push_back(16'h0102); fw.push_back(16'hAAAA); fw.push_back(16'hBBBB);
        fw.push_back(16'hFA5A); fw.push_back(16'hFA5A);
        send_all();
        repeat (2) @(negedge clk);
        chk("R1", "no done, no err", {254'd0, cfg_err, 1'b0} | 256'(done_cnt), 256'd0);
        check_hold("R1");

        // full frame: R2 padding, R3 scalars, R4 arrays, R5 mode bits 0 and 3
        fr_open();
        fr_s16(8'd0, 16'h0009);
        fr_s32(8'd1, 32'h0001_0002, 1);
        fr_s32(8'd3, 32'h00F0_0000, 2);
        fr_s32(8'd5, 32'h0000_1234, 1);
        fr_s16(8'd7, 16'hBEEF);
        fr_s32(8'd10, 32'hCAFE_0001, 0);
        fr_s32(8'd12, 32'h0BAD_F00D, 1);
        fr_arr(8'd16, 16'h1000); fr_arr(8'd17, 16'h2000);
        fr_arr(8'd20, 16'h3000); fr_arr(8'd21, 16'h4000);
        fr_arr(8'd24, 16'h5000); fr_arr(8'd25, 16'h6000);
        fr_arr(8'd28, 16'h7000); fr_arr(8'd29, 16'h8000);
        fr_arr(8'd32, 16'h9000); fr_arr(8'd33, 16'hA000);
        fr_close();
        send_good("R6");

        // R9 partial frame, R5 clock bits
        fr_open();
        fr_s16(8'd0, 16'h0006);
        fr_s32(8'd1, 32'h0000_0031, 3);
        fr_close();
        send_good("R9");

        // R8 unknown type after a payload written to the shadow
        dc = done_cnt;
        fr_open();
        fr_s32(8'd1, 32'hDEAD_DEAD, 1);
        fw.push_back(16'h0201);
        send_all();
        chk("R8", "err after unknown type", {255'd0, cfg_err}, 256'd1);
        check_hold("R7");
        repeat (3) @(negedge clk);
        chk("R8", "err stays set", {255'd0, cfg_err}, 256'd1);
        send_word(16'hF5A5);
        chk("R8", "err held after first sync word", {255'd0, cfg_err}, 256'd1);
        send_word(16'hF5A5);
        chk("R8", "err cleared by opening sync", {255'd0, cfg_err}, 256'd0);
        p = m;
        fr_s32(8'd3, 32'h0000_0777, 1);
        fr_close();
        send_good("R9");
        chk("R9", "aborted divider not kept", clk_divider, 256'h31);

        // R8 length mismatch on a scalar
        dc = done_cnt;
        fr_open();
        fw.push_back(16'h0002); fw.push_back(16'h0001); fw.push_back(16'h0002);
        fr_close();
        send_all();
        @(negedge clk);
        chk("R8", "bad scalar length flagged", {255'd0, cfg_err}, 256'd1);
        chk("R8", "no done after bad length", 256'(done_cnt - dc), 256'd0);
        check_hold("R7");

        // R8 length mismatch on an array
        fr_open();
        fw.push_back(16'h1008);
        send_all();
        chk("R8", "bad array length flagged", {255'd0, cfg_err}, 256'd1);

        // R8 bad second closing word
        dc = done_cnt;
        fr_open();
        fr_s16(8'd7, 16'h1111);
        fw.push_back(16'hFA5A); fw.push_back(16'h0000);
        send_all();
        chk("R8", "bad closing sync flagged", {255'd0, cfg_err}, 256'd1);
        @(negedge clk);
        chk("R8", "no done after bad close", 256'(done_cnt - dc), 256'd0);
        chk("R7", "global held", trig_global, m.glb);

        // R8 opening sync where a header is expected
        fr_open();
        fw.push_back(16'hF5A5);
        send_all();
        chk("R8", "nested sync flagged", {255'd0, cfg_err}, 256'd1);

        // back-to-back good frames
        fr_open();
        fr_s32(8'd5, 32'h0000_0042, 0);
        fr_arr(8'd25, 16'h0F0F);
        fr_close();
        send_good("R6");
        fr_open();
        fr_s16(8'd0, 16'h000F);
        fr_close();
        send_good("R5");

        repeat (4) @(negedge clk);
        chk("R6", "all frames seen", 256'(exp_q.size()), 256'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule